// File: doc/BRIEF.md
# Time Slot Interchange Output Engine

This block produces the transmit side of a time slot interchange switch. It drives eight serial TDM output lanes, each carrying 32 byte-wide channels per frame. Each bit is held for two system clocks, so one frame lasts 512 clocks. A 256-entry data memory holds the most recent received bytes. A 256-entry connection memory holds two bytes per output channel: a low byte and a high (control) byte. For every output time slot the engine reads both memories during the slot before. It picks either a switched byte from the data memory or a byte written by the processor. It then loads a shifter per lane.

Each lane also has a tri-state enable, so the lanes can share a bus with other drivers. A master enable input forces every lane to high impedance. A global processor-mode input makes every channel send its low byte with its enable on. A single control-channel line sends one bit per output channel, eight bits per time slot. The write ports of both memories model the processor side. Receive framing is not part of this block.

Top module: `tsi_out_engine`

## Requirements
- R1: A frame is 512 clock positions. When `frame_sync` is high at a rising edge, the next position is 0. Otherwise the position advances by one and wraps from 511 to 0. Position p belongs to channel p[8:4] and bit slot p[3:1].
- R2: Each lane sends its slot byte MSB first. Each bit lasts two clocks. The byte loaded at the last position of slot c-1 is on the line for the 16 positions of slot c.
- R3: In connection mode (high bit 2 = 0 and `proc_all` = 0), the lane sends the data memory byte at the address held in the low byte. The address is stream in bits 7:5 and channel in bits 4:0.
- R4: In processor mode (high bit 2 = 1, or `proc_all` = 1), the lane sends the low byte itself, every frame, until it is rewritten.
- R5: The connection memory entry of stream s for channel c+1 is read at the edge of sub-position s (0..7) of slot c. The data memory is read at the edge of sub-position s+1. A write at the same edge as a read is not seen by that read.
- R6: A lane's enable for a slot equals high bit 0 (or `proc_all`) of its entry. It is held for the whole slot.
- R7: When `master_oe` is low, all bits of `tx_oe` are 0 in the same cycle, whatever the per-channel bits say.
- R8: The control-channel line `cco` sends high bit 3 of each of the 8 entries of the slot, stream 0 first, each bit for two clocks.
- R9: `proc_all` is sampled at the load edge (last position of the previous slot). When it is set, that slot sends low bytes with all enables on.
- R10: While `rst` is high, `tx_data`, `tx_oe` and `cco` are 0 and the position returns to 0.
- R11: A frame pulse in the middle of a slot realigns the position without reloading the shifters. The shifted-out lanes send 0 until the next load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, two per serial bit |
| rst | input | 1 | Synchronous active-high reset |
| frame_sync | input | 1 | Frame alignment pulse |
| master_oe | input | 1 | Master output enable for all lanes |
| proc_all | input | 1 | Forces processor mode and enable on every channel |
| dm_we | input | 1 | Data memory write strobe |
| dm_waddr | input | 8 | Data memory write address {stream, channel} |
| dm_wdata | input | 8 | Data memory write byte |
| cm_we | input | 1 | Connection memory write strobe |
| cm_hi_sel | input | 1 | 1 writes the high (control) byte, 0 the low byte |
| cm_waddr | input | 8 | Connection memory address {stream, channel} |
| cm_wdata | input | 8 | Connection memory write byte |
| tx_data | output | 8 | Serial data, one bit per lane |
| tx_oe | output | 8 | Per-lane tri-state enable, active high |
| cco | output | 1 | Control-channel serial line |

## Verification
The main collision is a processor write that lands on the same edge as the fetch read of that same memory word. The bench provokes it by aiming half of its random writes at the connection entry or data byte that the sequencer reads at that edge. Its reference model applies writes only after taking each read, so a wrong read-versus-write order shows up one slot later as a wrong byte or enable. A second overlap comes from toggling `proc_all` and `master_oe` while channels with mixed control bits stream out. Each one is judged against the model on every clock.

// File: rtl/tsi_pkg.sv
package tsi_pkg;

    localparam int DATA_W      = 8;
    localparam int DEF_STREAMS = 8;
    localparam int DEF_CHANS   = 32;
    localparam int BIT_CYC     = 2;

    // control byte field positions
    localparam int HI_OE   = 0;
    localparam int HI_PROC = 2;
    localparam int HI_CCO  = 3;

    typedef logic [DATA_W-1:0] byte_t;

    typedef struct packed {
        byte_t low;
        byte_t high;
        byte_t dm;
    } slot_src_t;

    typedef struct packed {
        logic proc;
        logic oe;
        logic cco;
    } slot_ctl_t;

    function automatic slot_ctl_t decode_high(input byte_t h, input logic force_proc);
        slot_ctl_t c;
        c.proc = h[HI_PROC] | force_proc;
        c.oe   = h[HI_OE]   | force_proc;
        c.cco  = h[HI_CCO];
        return c;
    endfunction

    function automatic byte_t pick_source(input slot_src_t s, input logic proc);
        return proc ? s.low : s.dm;
    endfunction

endpackage

// File: rtl/tsi_frame_counter.sv
module tsi_frame_counter #(
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             frame_sync,
    output logic [CNT_W-1:0] pos
);

    always_ff @(posedge clk) begin
        if (rst)
            pos <= '0;
        else if (frame_sync)
            pos <= '0;
        else
            pos <= pos + 1'b1;
    end

    AST_FRAME_ALIGN: assert property (@(posedge clk) disable iff (rst)
        frame_sync |=> (pos == '0)); // R1

    AST_POS_STEP: assert property (@(posedge clk) disable iff (rst)
        !frame_sync |=> (pos == CNT_W'($past(pos) + 1'b1))); // R1

endmodule

// File: rtl/tsi_dpram.sv
module tsi_dpram #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // read returns the content from before a same-edge write
    always_ff @(posedge clk) begin
        if (we)
            mem[waddr] <= wdata;
        rdata <= mem[raddr];
    end

endmodule

// File: rtl/tsi_fetch.sv
module tsi_fetch
    import tsi_pkg::*;
#(
    parameter int N_STREAMS = DEF_STREAMS,
    parameter int CH_W      = 5,
    parameter int SUB_W     = 4,
    localparam int STR_W    = $clog2(N_STREAMS),
    localparam int AW       = STR_W + CH_W
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic [SUB_W-1:0]               sub,
    input  logic [CH_W-1:0]                cur_chan,
    input  byte_t                          cm_low_rd,
    input  byte_t                          cm_high_rd,
    input  byte_t                          dm_rd,
    output logic [AW-1:0]                  cm_raddr,
    output logic [AW-1:0]                  dm_raddr,
    output slot_src_t [N_STREAMS-1:0]      stage_q
);

    logic [CH_W-1:0]  next_chan;
    logic [STR_W-1:0] lane_sel;

    assign next_chan = cur_chan + 1'b1;
    assign lane_sel  = sub[STR_W-1:0];

    // sub-position s addresses lane s of the next channel
    assign cm_raddr  = {lane_sel, next_chan};
    // the low byte just read is the switching address
    assign dm_raddr  = cm_low_rd[AW-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= '0;
        end else begin
            for (int s = 0; s < N_STREAMS; s++) begin
                if (sub == SUB_W'(s + 1)) begin
                    stage_q[s].low  <= cm_low_rd;
                    stage_q[s].high <= cm_high_rd;
                end
                if (sub == SUB_W'(s + 2))
                    stage_q[s].dm <= dm_rd;
            end
        end
    end

    AST_STAGE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (sub >= SUB_W'(N_STREAMS + 2)) |=> $stable(stage_q)); // R5

endmodule

// File: rtl/tsi_serializer.sv
module tsi_serializer
    import tsi_pkg::*;
#(
    parameter int N_STREAMS = DEF_STREAMS
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      load,
    input  logic                      shift,
    input  logic                      proc_all,
    input  slot_src_t [N_STREAMS-1:0] src,
    output logic [N_STREAMS-1:0]      tx_bit,
    output logic [N_STREAMS-1:0]      oe_q,
    output logic                      cco_bit
);

    logic [N_STREAMS-1:0] cco_next;
    logic [N_STREAMS-1:0] cco_sh;

    for (genvar s = 0; s < N_STREAMS; s++) begin : g_lane
        slot_ctl_t ctl;
        byte_t     sh;
        logic      oe_r;

        assign ctl = decode_high(src[s].high, proc_all);
        // lane 0 sits at the top so it leaves first
        assign cco_next[N_STREAMS-1-s] = ctl.cco;

        always_ff @(posedge clk) begin
            if (rst) begin
                sh   <= '0;
                oe_r <= 1'b0;
            end else if (load) begin
                sh   <= pick_source(src[s], ctl.proc);
                oe_r <= ctl.oe;
            end else if (shift) begin
                sh   <= {sh[DATA_W-2:0], 1'b0};
            end
        end

        assign tx_bit[s] = sh[DATA_W-1];
        assign oe_q[s]   = oe_r;
    end

    always_ff @(posedge clk) begin
        if (rst)
            cco_sh <= '0;
        else if (load)
            cco_sh <= cco_next;
        else if (shift)
            cco_sh <= {cco_sh[N_STREAMS-2:0], 1'b0};
    end

    assign cco_bit = cco_sh[N_STREAMS-1];

    AST_OE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(oe_q)); // R6

    AST_FORCE_OE: assert property (@(posedge clk) disable iff (rst)
        (load && proc_all) |=> (&oe_q)); // R9

endmodule

// File: rtl/tsi_out_engine.sv
module tsi_out_engine
    import tsi_pkg::*;
#(
    parameter int N_STREAMS = DEF_STREAMS,
    parameter int N_CHANS   = DEF_CHANS,
    localparam int STR_W    = $clog2(N_STREAMS),
    localparam int CH_W     = $clog2(N_CHANS),
    localparam int AW       = STR_W + CH_W,
    localparam int SLOT_CYC = DATA_W * BIT_CYC,
    localparam int SUB_W    = $clog2(SLOT_CYC),
    localparam int CNT_W    = CH_W + SUB_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 frame_sync,
    input  logic                 master_oe,
    input  logic                 proc_all,
    input  logic                 dm_we,
    input  logic [AW-1:0]        dm_waddr,
    input  logic [DATA_W-1:0]    dm_wdata,
    input  logic                 cm_we,
    input  logic                 cm_hi_sel,
    input  logic [AW-1:0]        cm_waddr,
    input  logic [DATA_W-1:0]    cm_wdata,
    output logic [N_STREAMS-1:0] tx_data,
    output logic [N_STREAMS-1:0] tx_oe,
    output logic                 cco
);

    logic [CNT_W-1:0]          pos;
    logic [SUB_W-1:0]          sub;
    logic [CH_W-1:0]           cur_chan;
    logic                      load;
    logic                      shift;
    logic [AW-1:0]             cm_raddr;
    logic [AW-1:0]             dm_raddr;
    byte_t                     cm_low_rd;
    byte_t                     cm_high_rd;
    byte_t                     dm_rd;
    slot_src_t [N_STREAMS-1:0] stage_q;
    logic [N_STREAMS-1:0]      oe_q;

    tsi_frame_counter #(.CNT_W(CNT_W)) u_count (
        .clk        (clk),
        .rst        (rst),
        .frame_sync (frame_sync),
        .pos        (pos)
    );

    assign sub      = pos[SUB_W-1:0];
    assign cur_chan = pos[CNT_W-1:SUB_W];
    assign load     = (sub == SUB_W'(SLOT_CYC - 1));
    assign shift    = sub[0] & ~load;

    tsi_dpram #(.AW(AW), .DW(DATA_W)) u_dmem (
        .clk   (clk),
        .we    (dm_we),
        .waddr (dm_waddr),
        .wdata (dm_wdata),
        .raddr (dm_raddr),
        .rdata (dm_rd)
    );

    tsi_dpram #(.AW(AW), .DW(DATA_W)) u_cm_low (
        .clk   (clk),
        .we    (cm_we & ~cm_hi_sel),
        .waddr (cm_waddr),
        .wdata (cm_wdata),
        .raddr (cm_raddr),
        .rdata (cm_low_rd)
    );

    tsi_dpram #(.AW(AW), .DW(DATA_W)) u_cm_high (
        .clk   (clk),
        .we    (cm_we & cm_hi_sel),
        .waddr (cm_waddr),
        .wdata (cm_wdata),
        .raddr (cm_raddr),
        .rdata (cm_high_rd)
    );

    tsi_fetch #(
        .N_STREAMS (N_STREAMS),
        .CH_W      (CH_W),
        .SUB_W     (SUB_W)
    ) u_fetch (
        .clk        (clk),
        .rst        (rst),
        .sub        (sub),
        .cur_chan   (cur_chan),
        .cm_low_rd  (cm_low_rd),
        .cm_high_rd (cm_high_rd),
        .dm_rd      (dm_rd),
        .cm_raddr   (cm_raddr),
        .dm_raddr   (dm_raddr),
        .stage_q    (stage_q)
    );

    tsi_serializer #(.N_STREAMS(N_STREAMS)) u_ser (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .shift    (shift),
        .proc_all (proc_all),
        .src      (stage_q),
        .tx_bit   (tx_data),
        .oe_q     (oe_q),
        .cco_bit  (cco)
    );

    assign tx_oe = oe_q & {N_STREAMS{master_oe}};

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (tx_data == '0 && oe_q == '0 && cco == 1'b0)); // R10

endmodule

// File: tb/tsi_out_engine_tb.sv
module tsi_out_engine_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       frame_sync = 1'b0;
    logic       master_oe = 1'b0;
    logic       proc_all = 1'b0;
    logic       dm_we = 1'b0;
    logic [7:0] dm_waddr = '0;
    logic [7:0] dm_wdata = '0;
    logic       cm_we = 1'b0;
    logic       cm_hi_sel = 1'b0;
    logic [7:0] cm_waddr = '0;
    logic [7:0] cm_wdata = '0;
    logic [7:0] tx_data;
    logic [7:0] tx_oe;
    logic       cco;

    tsi_out_engine u_dut (
        .clk(clk), .rst(rst), .frame_sync(frame_sync), .master_oe(master_oe),
        .proc_all(proc_all), .dm_we(dm_we), .dm_waddr(dm_waddr), .dm_wdata(dm_wdata),
        .cm_we(cm_we), .cm_hi_sel(cm_hi_sel), .cm_waddr(cm_waddr), .cm_wdata(cm_wdata),
        .tx_data(tx_data), .tx_oe(tx_oe), .cco(cco)
    );

    always #10 clk = ~clk;

    int    n_vec = 0;
    int    n_bad = 0;
    int    cycles = 0;
    bit    chk_en = 1'b0;
    bit    done = 1'b0;
    bit    realign_arm = 1'b0;
    string cur_req = "R10";

    // reference model state
    int         m_cnt = 0;
    int         m_bit = 0;
    logic [7:0] dm_m  [256];
    logic [7:0] cml_m [256];
    logic [7:0] cmh_m [256];
    logic [7:0] m_cl  [8];
    logic [7:0] m_ch  [8];
    logic [7:0] m_dv  [8];
    logic [7:0] e_byte[8];
    logic [7:0] e_oe = '0;
    logic [7:0] e_cco = '0;

    initial begin
        for (int i = 0; i < 256; i++) begin
            dm_m[i] = '0; cml_m[i] = '0; cmh_m[i] = '0;
        end
        for (int s = 0; s < 8; s++) begin
            m_cl[s] = '0; m_ch[s] = '0; m_dv[s] = '0; e_byte[s] = '0;
        end
    end

    function automatic logic [7:0] exp_tx();
        logic [7:0] v;
        for (int s = 0; s < 8; s++)
            v[s] = (m_bit < 8) ? e_byte[s][7 - m_bit] : 1'b0;
        return v;
    endfunction

    function automatic logic exp_cco();
        return (m_bit < 8) ? e_cco[m_bit] : 1'b0;
    endfunction

    // model step on each edge, comparison away from the edge
    always @(posedge clk) begin
        int sub;
        int nxt;
        bit ld;
        bit sh;
        sub = m_cnt & 15;
        nxt = ((m_cnt >> 4) + 1) & 31;
        ld  = (sub == 15);
        sh  = ((m_cnt & 1) == 1) && !ld;
        if (rst) begin
            m_cnt = 0;
            m_bit = 0;
            e_oe  = '0;
            e_cco = '0;
            for (int s = 0; s < 8; s++) begin
                e_byte[s] = '0; m_cl[s] = '0; m_ch[s] = '0; m_dv[s] = '0;
            end
        end else begin
            if (sub >= 1 && sub <= 8)
                m_dv[sub-1] = dm_m[m_cl[sub-1]];
            if (sub <= 7) begin
                m_cl[sub] = cml_m[sub*32 + nxt];
                m_ch[sub] = cmh_m[sub*32 + nxt];
            end
            if (ld) begin
                for (int s = 0; s < 8; s++) begin
                    e_byte[s] = (m_ch[s][2] | proc_all) ? m_cl[s] : m_dv[s];
                    e_oe[s]   = m_ch[s][0] | proc_all;
                    e_cco[s]  = m_ch[s][3];
                end
                m_bit = 0;
            end else if (sh && m_bit < 8) begin
                m_bit = m_bit + 1;
            end
            m_cnt = frame_sync ? 0 : ((m_cnt + 1) & 511);
        end
        if (dm_we) dm_m[dm_waddr] = dm_wdata;
        if (cm_we) begin
            if (cm_hi_sel) cmh_m[cm_waddr] = cm_wdata;
            else           cml_m[cm_waddr] = cm_wdata;
        end
        #5;
        if (chk_en && !done) begin
            logic [7:0] xt;
            logic [7:0] xo;
            logic       xc;
            xt = exp_tx();
            xo = e_oe & {8{master_oe}};
            xc = exp_cco();
            n_vec++;
            if (tx_data !== xt || tx_oe !== xo || cco !== xc) begin
                n_bad++;
                if (tx_data !== xt)
                    $display("FAIL [R2 R3 R4 R5 | %s] tx_data actual=%h expected=%h pos=%0d", cur_req, tx_data, xt, m_cnt);
                if (tx_oe !== xo)
                    $display("FAIL [R6 R7 R9 | %s] tx_oe actual=%h expected=%h pos=%0d", cur_req, tx_oe, xo, m_cnt);
                if (cco !== xc)
                    $display("FAIL [R8 | %s] cco actual=%b expected=%b pos=%0d", cur_req, cco, xc, m_cnt);
            end
        end
    end

    // all stimulus changes at the falling edge
    task automatic tick();
        @(negedge clk);
        frame_sync = (m_cnt == 511) || (realign_arm && m_cnt == 92);
        if (realign_arm && m_cnt == 92) realign_arm = 1'b0;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            n_bad++;
            $display("FAIL [R1] watchdog actual=%0d cycles expected=below 100000", cycles);
            finish_run();
        end
    end

    task automatic rand_write(bit aimed);
        int sub;
        int nxt;
        sub = m_cnt & 15;
        nxt = ((m_cnt >> 4) + 1) & 31;
        dm_we     = $urandom_range(0, 1);
        cm_we     = $urandom_range(0, 1);
        cm_hi_sel = $urandom_range(0, 1);
        cm_wdata  = 8'($urandom);
        dm_wdata  = 8'($urandom);
        if (aimed) begin
            cm_waddr = 8'(((sub & 7) << 5) | nxt);
            dm_waddr = (sub >= 1 && sub <= 8) ? m_cl[sub-1] : 8'($urandom);
        end else begin
            cm_waddr = 8'($urandom);
            dm_waddr = 8'($urandom);
        end
    endtask

    initial begin
        // R10: reset state
        repeat (3) tick();
        n_vec++;
        if (tx_data !== 8'h00 || tx_oe !== 8'h00 || cco !== 1'b0) begin
            n_bad++;
            $display("FAIL [R10] reset outputs actual=%h/%h/%b expected=00/00/0", tx_data, tx_oe, cco);
        end
        rst = 1'b0;

        // fill memories: low byte = source address, high byte = mixed control
        for (int a = 0; a < 256; a++) begin
            tick();
            dm_we = 1'b1; dm_waddr = 8'(a); dm_wdata = 8'((a * 7 + 3) ^ 8'h5a);
        end
        tick(); dm_we = 1'b0;
        for (int a = 0; a < 256; a++) begin
            tick();
            cm_we = 1'b1; cm_hi_sel = 1'b0; cm_waddr = 8'(a); cm_wdata = 8'((a * 37 + 11) & 255);
        end
        for (int a = 0; a < 256; a++) begin
            tick();
            cm_we = 1'b1; cm_hi_sel = 1'b1; cm_waddr = 8'(a);
            cm_wdata = {4'b0, 1'((a & 1) ^ ((a >> 3) & 1)), 1'((a % 3) == 0), 1'b0, 1'((a % 5) != 0)};
        end
        tick(); cm_we = 1'b0;
        master_oe = 1'b1;
        repeat (40) tick();
        chk_en = 1'b1;

        cur_req = "R1 R2 R3 R4 R6 R8 static map";
        repeat (1024) tick();

        cur_req = "R5 writes racing fetch";
        for (int i = 0; i < 1024; i++) begin
            tick();
            rand_write(i[0]);
        end
        tick(); dm_we = 1'b0; cm_we = 1'b0;

        cur_req = "R9 R4 global processor mode";
        for (int i = 0; i < 700; i++) begin
            tick();
            if ((i % 100) == 0) proc_all = ~proc_all;
        end
        tick(); proc_all = 1'b0;

        cur_req = "R7 master enable toggling";
        for (int i = 0; i < 300; i++) begin
            tick();
            master_oe = $urandom_range(0, 1);
        end
        tick(); master_oe = 1'b1;

        cur_req = "R11 R1 mid-slot realignment";
        realign_arm = 1'b1;
        repeat (1100) tick();

        cur_req = "R3 R4 R5 R6 R7 R9 mixed";
        for (int i = 0; i < 1000; i++) begin
            tick();
            rand_write(i[1]);
            if ((i % 37) == 0) proc_all = $urandom_range(0, 1);
            master_oe = ($urandom_range(0, 7) != 0);
        end
        tick(); dm_we = 1'b0; cm_we = 1'b0;
        repeat (20) tick();
        finish_run();
    end

endmodule